// File: doc/BRIEF.md
# MMU Fault Status and Control Registers

This block is the software-visible register front end of a small I/O memory management unit. The translation datapath sends it one-cycle fault pulses in five classes, together with the device address of the access that faulted. The block latches the fault classes into a sticky status register, keeps the address of the first fault, and raises a single level interrupt whenever a latched fault is also enabled. Software clears the latched faults by writing ones to the status register.

Software also programs a control register. Its three enable bits go straight back to the datapath: MMU enable, table-walk enable and emulator-TLB enable. Writing zeros to that field shuts the MMU down. The block also holds a translation-table base register aligned to 16 KiB and a fixed revision word. Access is through a simple synchronous register bus. Writes take effect on the rising clock edge. Read data is combinational from the word address.

Top module: `mmu_fault_regs`

## Requirements
- R1: After reset every writable register reads zero, `irqOut` and the three enable outputs are low, and the revision word still reads 0x11.
- R2: A pulse on `faultPulse[i]` sets status bit i, which reads at word address 1 and stays set. The bit meanings are: bit 0 TLB miss, bit 1 translation fault, bit 2 emulator miss, bit 3 table-walk fault, bit 4 multi-hit fault.
- R3: A write to word address 1 clears each status bit that is 1 in the written data and leaves the other bits alone. If a fault arrives on the same edge as a clear of the same bit, the fault wins.
- R4: The interrupt enable register at word address 2 uses the same five-bit layout as the status register and reads back what was written in bits 4:0.
- R5: `irqOut` is high exactly when some status bit and its matching enable bit are both 1.
- R6: The control register is at word address 3. Bit 1 drives `mmuEnable`, bit 2 drives `walkEnable` and bit 3 drives `emuTlbEnable`. Writing zeros to bits 3:1 turns all three outputs off on the next edge.
- R7: The fault address register at word address 4 captures `faultAddr` only when a fault pulse arrives while no status bit is set. It holds that value until the status is cleared and a new fault arrives.
- R8: The table base register at word address 5 stores bits 31:14 of the written value. Bits 13:0 always read zero.
- R9: The revision register at word address 0 reads 0x11: major version 1 in bits 7:4 and minor version 1 in bits 3:0. Writes to it have no effect.
- R10: Unused bits of every register read zero. So does control bit 0, whatever is written to it. Word addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| faultPulse | input | 5 | One-cycle fault indications, in status bit order |
| faultAddr | input | 32 | Device address of the faulting access |
| irqOut | output | 1 | Level interrupt |
| mmuEnable | output | 1 | Translation enable to the datapath |
| walkEnable | output | 1 | Table-walk enable to the datapath |
| emuTlbEnable | output | 1 | Emulator-TLB enable to the datapath |

## Verification
The assertions assume that reset is held for at least one edge before any fault pulse is checked, and that `faultPulse` and the write strobe change only between edges. The bench drives every input on the falling edge and holds faults at zero during reset. It raises faults only in planned cycles, including one cycle where a fault and a status clear land together. This lets the set-wins-over-clear rule and the first-fault capture rule be checked against a known prior state.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  // Register word addresses
  localparam int ADR_REV   = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_IEN   = 2;
  localparam int ADR_CTL   = 3;
  localparam int ADR_FADDR = 4;
  localparam int ADR_BASE  = 5;

  localparam logic [7:0] REV_VALUE = 8'h11;

  // Enable field position inside the control word
  localparam int CTL_LSB = 1;
  localparam int CTL_W   = 3;

  typedef struct packed {
    logic wrStat;
    logic wrIen;
    logic wrCtl;
    logic wrBase;
  } regStrobes_t;
endpackage

// File: rtl/mmu_regs_ctrl.sv
module mmu_regs_ctrl
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      strobes.wrStat = (regAddr == ADDR_W'(ADR_STAT));
      strobes.wrIen  = (regAddr == ADDR_W'(ADR_IEN));
      strobes.wrCtl  = (regAddr == ADDR_W'(ADR_CTL));
      strobes.wrBase = (regAddr == ADDR_W'(ADR_BASE));
    end
  end
endmodule

// File: rtl/mmu_regs_dp.sv
module mmu_regs_dp
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int FAULT_N    = 5,
  parameter int ALIGN_BITS = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strobes,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [FAULT_N-1:0] faultPulse,
  input  logic [DATA_W-1:0]  faultAddr,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut,
  output logic [CTL_W-1:0]   ctlQ,
  output logic [FAULT_N-1:0] statusQ,
  output logic [FAULT_N-1:0] enableQ,
  output logic [DATA_W-1:0]  faultAddrQ
);
  localparam int BASE_W = DATA_W - ALIGN_BITS;

  logic [BASE_W-1:0] baseQ;
  logic              capture;

  // Sticky status bits: a fault on the same edge beats a clear
  for (genvar i = 0; i < FAULT_N; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              statusQ[i] <= 1'b0;
      else if (faultPulse[i]) statusQ[i] <= 1'b1;
      else if (strobes.wrStat && regWrData[i]) statusQ[i] <= 1'b0;
    end
  end

  assign capture = (|faultPulse) && (statusQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ    <= '0;
      ctlQ       <= '0;
      baseQ      <= '0;
      faultAddrQ <= '0;
    end else begin
      if (strobes.wrIen)  enableQ <= regWrData[FAULT_N-1:0];
      if (strobes.wrCtl)  ctlQ    <= regWrData[CTL_LSB +: CTL_W];
      if (strobes.wrBase) baseQ   <= regWrData[DATA_W-1:ALIGN_BITS];
      if (capture)        faultAddrQ <= faultAddr;
    end
  end

  assign irqOut = |(statusQ & enableQ);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADR_REV):   regRdData[7:0]                   = REV_VALUE;
      ADDR_W'(ADR_STAT):  regRdData[FAULT_N-1:0]           = statusQ;
      ADDR_W'(ADR_IEN):   regRdData[FAULT_N-1:0]           = enableQ;
      ADDR_W'(ADR_CTL):   regRdData[CTL_LSB +: CTL_W]      = ctlQ;
      ADDR_W'(ADR_FADDR): regRdData                        = faultAddrQ;
      ADDR_W'(ADR_BASE):  regRdData[DATA_W-1:ALIGN_BITS]   = baseQ;
      default:            regRdData                        = '0;
    endcase
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int FAULT_N    = 5,
  parameter int ALIGN_BITS = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [FAULT_N-1:0] faultPulse,
  input  logic [DATA_W-1:0]  faultAddr,
  output logic               irqOut,
  output logic               mmuEnable,
  output logic               walkEnable,
  output logic               emuTlbEnable
);
  regStrobes_t        strobes;
  logic [CTL_W-1:0]   ctlQ;
  logic [FAULT_N-1:0] statusQ;
  logic [FAULT_N-1:0] enableQ;
  logic [DATA_W-1:0]  faultAddrQ;

  mmu_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  mmu_regs_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAULT_N(FAULT_N), .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .faultPulse (faultPulse),
    .faultAddr  (faultAddr),
    .regRdData  (regRdData),
    .irqOut     (irqOut),
    .ctlQ       (ctlQ),
    .statusQ    (statusQ),
    .enableQ    (enableQ),
    .faultAddrQ (faultAddrQ)
  );

  assign mmuEnable    = ctlQ[0];
  assign walkEnable   = ctlQ[1];
  assign emuTlbEnable = ctlQ[2];
endmodule

// File: rtl/mmu_fault_regs_chk.sv
module mmu_fault_regs_chk
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int FAULT_N = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic [FAULT_N-1:0] faultPulse,
  input logic               irqOut,
  input logic               mmuEnable,
  input logic               walkEnable,
  input logic               emuTlbEnable,
  input logic [FAULT_N-1:0] statusQ,
  input logic [DATA_W-1:0]  faultAddrQ
);
  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (faultPulse != '0) |=> ((statusQ & $past(faultPulse)) == $past(faultPulse))); // R2

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADR_STAT))
      |=> ((statusQ & $past(regWrData[FAULT_N-1:0]) & ~$past(faultPulse)) == '0)); // R3

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0)); // R5

  AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(ADR_CTL) && regWrData[CTL_LSB +: CTL_W] == '0)
      |=> (!mmuEnable && !walkEnable && !emuTlbEnable)); // R6

  AST_FIRST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ != '0) |=> $stable(faultAddrQ)); // R7

  AST_REVISION_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(ADR_REV)) |-> (regRdData == DATA_W'(REV_VALUE))); // R9
endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAULT_N(FAULT_N)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regAddr      (regAddr),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .faultPulse   (faultPulse),
  .irqOut       (irqOut),
  .mmuEnable    (mmuEnable),
  .walkEnable   (walkEnable),
  .emuTlbEnable (emuTlbEnable),
  .statusQ      (statusQ),
  .faultAddrQ   (faultAddrQ)
);

// File: tb/mmu_fault_regs_test.sv
module mmu_fault_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  faultPulse = '0;
  logic [31:0] faultAddr = '0;
  logic        irqOut, mmuEnable, walkEnable, emuTlbEnable;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fault_regs uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .faultPulse(faultPulse),
    .faultAddr(faultAddr), .irqOut(irqOut), .mmuEnable(mmuEnable),
    .walkEnable(walkEnable), .emuTlbEnable(emuTlbEnable)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [4:0]  fault;
    logic [31:0] faddr;
    logic [2:0]  rdAddr;
    logic [31:0] expRd;
    logic        expIrq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,        5'b00001, 32'h1000_0040, 3'd1, 32'h01,        1'b0, 8'd2},  // R2 TLB miss
    '{1'b0, 3'd0, 32'h0,        5'b01000, 32'h2222_0000, 3'd4, 32'h1000_0040, 1'b0, 8'd7},  // R7 first kept
    '{1'b0, 3'd0, 32'h0,        5'b00000, 32'h0,         3'd1, 32'h09,        1'b0, 8'd2},  // R2 sticky
    '{1'b1, 3'd2, 32'hFFFF_FFFF,5'b00000, 32'h0,         3'd2, 32'h1F,        1'b1, 8'd4},  // R4
    '{1'b1, 3'd1, 32'h01,       5'b00000, 32'h0,         3'd1, 32'h08,        1'b1, 8'd3},  // R3 partial clear
    '{1'b1, 3'd1, 32'h08,       5'b00000, 32'h0,         3'd1, 32'h00,        1'b0, 8'd3},  // R3
    '{1'b0, 3'd0, 32'h0,        5'b10000, 32'hABCD_0123, 3'd4, 32'hABCD_0123, 1'b1, 8'd7},  // R7 recapture
    '{1'b1, 3'd1, 32'h10,       5'b00100, 32'h5555_0000, 3'd1, 32'h04,        1'b1, 8'd3},  // R3 set and clear
    '{1'b0, 3'd0, 32'h0,        5'b00000, 32'h0,         3'd4, 32'hABCD_0123, 1'b1, 8'd7},  // R7 no capture
    '{1'b1, 3'd2, 32'h02,       5'b00000, 32'h0,         3'd1, 32'h04,        1'b0, 8'd5},  // R5 masked
    '{1'b0, 3'd0, 32'h0,        5'b00010, 32'h0,         3'd1, 32'h06,        1'b1, 8'd5},  // R5 enabled hit
    '{1'b1, 3'd3, 32'hFFFF_FFFF,5'b00000, 32'h0,         3'd3, 32'h0E,        1'b1, 8'd10}, // R10 ctl bit0
    '{1'b1, 3'd5, 32'h1234_5FFF,5'b00000, 32'h0,         3'd5, 32'h1234_4000, 1'b1, 8'd8},  // R8
    '{1'b1, 3'd0, 32'hFFFF_FFFF,5'b00000, 32'h0,         3'd0, 32'h11,        1'b1, 8'd9},  // R9
    '{1'b1, 3'd6, 32'hFFFF_FFFF,5'b00000, 32'h0,         3'd6, 32'h0,         1'b1, 8'd10}, // R10 hole
    '{1'b1, 3'd3, 32'h0,        5'b00000, 32'h0,         3'd3, 32'h0,         1'b1, 8'd6},  // R6 shutdown
    '{1'b1, 3'd1, 32'h1F,       5'b00000, 32'h0,         3'd1, 32'h0,         1'b0, 8'd3}   // R3 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic [2:0] addr, input logic [31:0] wdata,
                       input logic [4:0] fault, input logic [31:0] faddr, input logic [2:0] rdAddr);
    @(negedge clk);
    regWrEn = we; regAddr = addr; regWrData = wdata;
    faultPulse = fault; faultAddr = faddr;
    @(negedge clk);
    regWrEn = 1'b0; faultPulse = '0; regAddr = rdAddr;
    #1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #1;
      check("R1", regRdData, (a == 0) ? 32'h11 : 32'h0);
    end
    check("R1", {29'b0, mmuEnable, walkEnable, emuTlbEnable}, 32'h0);
    check("R1", {31'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      cycle(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].fault, VECS[v].faddr, VECS[v].rdAddr);
      check($sformatf("R%0d rd vec%0d", VECS[v].req, v), regRdData, VECS[v].expRd);
      check($sformatf("R%0d irq vec%0d", VECS[v].req, v), {31'b0, irqOut}, {31'b0, VECS[v].expIrq});
    end

    // R6 enable outputs by bit
    cycle(1'b1, 3'd3, 32'h4, 5'b0, 32'h0, 3'd3);
    check("R6 walk only", {29'b0, emuTlbEnable, walkEnable, mmuEnable}, 32'h2);
    cycle(1'b1, 3'd3, 32'hA, 5'b0, 32'h0, 3'd3);
    check("R6 mmu+emu", {29'b0, emuTlbEnable, walkEnable, mmuEnable}, 32'h5);
    cycle(1'b1, 3'd3, 32'h1, 5'b0, 32'h0, 3'd3);
    check("R6 shutdown outputs", {29'b0, emuTlbEnable, walkEnable, mmuEnable}, 32'h0);
    check("R10 ctl bit0 ignored", regRdData, 32'h0);

    // R1 reset mid-run clears latched faults and capture
    cycle(1'b0, 3'd0, 32'h0, 5'b00011, 32'hDEAD_0000, 3'd1);
    check("R2 two faults", regRdData, 32'h03);
    @(negedge clk); rstN = 1'b0; #1;
    check("R1 status after reset", regRdData, 32'h0);
    regAddr = 3'd4; #1;
    check("R1 fault address after reset", regRdData, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    finishRun();
  end
endmodule